// File: doc/BRIEF.md
# Multiplexed Local Bus Slave

This block is the user-logic end of a synchronous local bus on which address and data share one set of wires. The bridge side opens a transfer with an active-low address strobe. In that cycle it places the address on the bus together with a direction bit. Data beats follow from the next cycle on. The slave paces each beat with an active-low ready output. The master closes the transfer with an active-low last-beat marker.

Accesses to any nonzero address go to a register file through a plain strobe interface. The register file reports per address whether it is mapped. Unmapped writes are accepted and dropped, and unmapped reads return zero. Address zero is reserved as the drain of a first-word-fall-through data queue. Block reads there stream queue words out, one word per completed beat, and stall while the queue is empty. The shared bus appears as separate in, out and output-enable vectors, so the pad tristate can sit at the chip edge.

Top module: `lbus_slave`

## Requirements
- R1: With `bus_rst_n` low at a rising edge (synchronous), the block returns to idle. In idle, `rdy_n` is 1, `ad_oe` is 0, and `reg_wr`, `reg_rd` and `fifo_pop` are 0.
- R2: In idle, a cycle with `ads_n` low captures bits [15:0] of `ad_i` as the address and `wr_nrd` as the direction (0 = read, 1 = write). The first data beat can complete in the following cycle.
- R3: On a write beat to a nonzero address that the register file reports as mapped, `reg_wr` is high, `reg_addr` holds the beat address, and `reg_wdata` equals `ad_i`. Writes to unmapped addresses or to address 0 still complete with `rdy_n` low, but `reg_wr` stays 0.
- R4: On a read beat to a mapped nonzero address, `ad_o` carries `reg_rdata` for that address while `rdy_n` is low.
- R5: On a read beat to an unmapped nonzero address, `ad_o` is 0 and the beat still completes.
- R6: For transfers that start at a nonzero address, each completed beat moves the address up by 4 (one 32-bit word).
- R7: A read that starts at address 0 returns queue words in queue order, one per completed beat. `fifo_pop` is high exactly on those beats, and the address stays at 0.
- R8: During a block read at address 0, an empty queue holds `rdy_n` high and `fifo_pop` low until data arrives. The beat then completes.
- R9: A transfer ends only on a completed beat (`rdy_n` low) that has `last_n` low. After that beat, `rdy_n` returns high. `last_n` low during a stalled cycle does not end the transfer.
- R10: `ad_oe` is high only in the data phase of a read. It is low in the address cycle, during writes, and from the cycle after the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Synchronous bus reset, active low |
| ads_n | input | 1 | Address strobe, active low |
| wr_nrd | input | 1 | Direction: 1 write, 0 read |
| last_n | input | 1 | Final beat marker, active low |
| ad_i | input | DATA_W | Shared bus, inbound value |
| ad_o | output | DATA_W | Shared bus, outbound value |
| ad_oe | output | 1 | Drive enable for the shared bus |
| rdy_n | output | 1 | Beat ready, active low |
| reg_addr | output | 16 | Current register address |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_wdata | output | DATA_W | Register write data |
| reg_rdata | input | DATA_W | Register read data |
| reg_hit | input | 1 | Register file maps `reg_addr` |
| fifo_data | input | DATA_W | Head word of the data queue |
| fifo_empty | input | 1 | Data queue empty |
| fifo_pop | output | 1 | Consume the head word |

## Verification
The bench targets a queue that runs dry mid-burst. A design that ignored emptiness would pop and return a stale word, and one that acted on `last_n` during a stall would drop out of the burst with words still owed. Bursts that cross from the mapped window into unmapped space show whether the address steps per beat, and whether unmapped reads return zero instead of stale register data. Writes to unmapped addresses and to the queue address must not raise `reg_wr`; a design that leaked them would corrupt the register model and the later readback. A reset taken mid-read must release the bus at once.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    localparam int unsigned ADDR_W = 16;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DATA = 1'b1
    } lbs_state_e;

    // Transfer context captured in the address cycle
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              is_write;
        logic              is_fifo;
    } lbs_ctx_t;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                     input logic [ADDR_W-1:0] stride);
        return a + stride;
    endfunction

endpackage

// File: rtl/lbs_addr_latch.sv
module lbs_addr_latch
    import lbs_pkg::*;
#(
    parameter int unsigned        STRIDE    = 4,
    parameter logic [ADDR_W-1:0]  FIFO_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              advance,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_nrd,
    output lbs_ctx_t          ctx
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx <= '0;
        end else if (capture) begin
            ctx.addr     <= addr_in;
            ctx.is_write <= wr_nrd;
            ctx.is_fifo  <= (addr_in == FIFO_ADDR);
        end else if (advance) begin
            ctx.addr <= step_addr(ctx.addr, STEP);
        end
    end

    // R6: register-space beats walk the address one word at a time
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !capture) |=> (ctx.addr == $past(ctx.addr) + STEP));

    // R7: the queue port never moves off its address
    p_fifo_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx.is_fifo && !capture) |=> (ctx.addr == $past(ctx.addr)));

endmodule

// File: rtl/lbs_ctrl.sv
module lbs_ctrl
    import lbs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ads_n,
    input  logic     last_n,
    input  lbs_ctx_t ctx,
    input  logic     fifo_empty,
    output logic     in_data,
    output logic     capture,
    output logic     advance,
    output logic     beat,
    output logic     rdy_n,
    output logic     fifo_pop
);

    lbs_state_e st, st_nx;
    logic       fifo_rd;

    always_comb begin
        fifo_rd  = ctx.is_fifo && !ctx.is_write;
        in_data  = (st == ST_DATA);
        beat     = in_data && !(fifo_rd && fifo_empty);
        rdy_n    = !beat;
        capture  = (st == ST_IDLE) && !ads_n;
        advance  = beat && !ctx.is_fifo;
        fifo_pop = beat && fifo_rd;
        st_nx    = st;
        unique case (st)
            ST_IDLE: if (capture)          st_nx = ST_DATA;
            ST_DATA: if (beat && !last_n)  st_nx = ST_IDLE;
            default:                       st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    p_data_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> in_data);

    p_end_on_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !last_n) |=> !in_data);

    p_stall_keeps_transfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !beat) |=> in_data);

    p_no_pop_when_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !fifo_pop);

endmodule

// File: rtl/lbs_rdmux.sv
module lbs_rdmux
    import lbs_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              in_data,
    input  lbs_ctx_t          ctx,
    input  logic              reg_hit,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] fifo_data,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe
);

    always_comb begin
        ad_oe = in_data && !ctx.is_write;
        if (!ad_oe)           ad_o = '0;
        else if (ctx.is_fifo) ad_o = fifo_data;
        else if (reg_hit)     ad_o = reg_rdata;
        else                  ad_o = '0;
    end

endmodule

// File: rtl/lbus_slave.sv
module lbus_slave
    import lbs_pkg::*;
#(
    parameter int unsigned       DATA_W    = 32,
    parameter int unsigned       STRIDE    = 4,
    parameter logic [ADDR_W-1:0] FIFO_ADDR = '0
) (
    input  logic              clk,
    input  logic              bus_rst_n,
    input  logic              ads_n,
    input  logic              wr_nrd,
    input  logic              last_n,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    output logic              rdy_n,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_hit,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_pop
);

    lbs_ctx_t ctx;
    logic     in_data, capture, advance, beat;
    logic     reg_beat;

    lbs_addr_latch #(
        .STRIDE    (STRIDE),
        .FIFO_ADDR (FIFO_ADDR)
    ) u_latch (
        .clk     (clk),
        .rst_n   (bus_rst_n),
        .capture (capture),
        .advance (advance),
        .addr_in (ad_i[ADDR_W-1:0]),
        .wr_nrd  (wr_nrd),
        .ctx     (ctx)
    );

    lbs_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (bus_rst_n),
        .ads_n      (ads_n),
        .last_n     (last_n),
        .ctx        (ctx),
        .fifo_empty (fifo_empty),
        .in_data    (in_data),
        .capture    (capture),
        .advance    (advance),
        .beat       (beat),
        .rdy_n      (rdy_n),
        .fifo_pop   (fifo_pop)
    );

    lbs_rdmux #(
        .DATA_W (DATA_W)
    ) u_rdmux (
        .in_data   (in_data),
        .ctx       (ctx),
        .reg_hit   (reg_hit),
        .reg_rdata (reg_rdata),
        .fifo_data (fifo_data),
        .ad_o      (ad_o),
        .ad_oe     (ad_oe)
    );

    always_comb begin
        reg_beat  = beat && !ctx.is_fifo && reg_hit;
        reg_addr  = ctx.addr;
        reg_wdata = ad_i;
        reg_wr    = reg_beat && ctx.is_write;
        reg_rd    = reg_beat && !ctx.is_write;
    end

    p_wr_only_mapped_r3: assert property (@(posedge clk) disable iff (!bus_rst_n)
        reg_wr |-> (reg_hit && !ad_oe && !rdy_n));

    p_oe_released_r10: assert property (@(posedge clk) disable iff (!bus_rst_n)
        (beat && !last_n) |=> !ad_oe);

    p_oe_not_in_addr_cycle_r10: assert property (@(posedge clk) disable iff (!bus_rst_n)
        capture |-> !ad_oe);

    p_pop_carries_head_r7: assert property (@(posedge clk) disable iff (!bus_rst_n)
        fifo_pop |-> (ad_oe && ad_o == fifo_data));

endmodule

// File: tb/lbus_slave_bench.sv
module lbus_slave_bench;
    import lbs_pkg::*;

    localparam int DW = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          bus_rst_n, ads_n, wr_nrd, last_n;
    logic [DW-1:0] ad_i, ad_o, reg_wdata, reg_rdata, fifo_data;
    logic          ad_oe, rdy_n, reg_wr, reg_rd, reg_hit, fifo_empty, fifo_pop;
    logic [15:0]   reg_addr;

    lbus_slave u_lbus_slave (
        .clk(clk), .bus_rst_n(bus_rst_n), .ads_n(ads_n), .wr_nrd(wr_nrd),
        .last_n(last_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .rdy_n(rdy_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_hit(reg_hit), .fifo_data(fifo_data),
        .fifo_empty(fifo_empty), .fifo_pop(fifo_pop)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // register file model: words 0x10..0x2C are mapped
    logic [DW-1:0] regs [8] = '{default: '0};
    logic [DW-1:0] exp_regs [8] = '{default: '0};
    logic [DW-1:0] fmem [16] = '{default: '0};
    int fhead = 0;
    int ftail = 0;

    function automatic bit mapped(input logic [15:0] a);
        return (a >= 16'h0010) && (a <= 16'h002C) && (a[1:0] == 2'b00);
    endfunction

    function automatic int ridx(input logic [15:0] a);
        return int'((a - 16'h0010) >> 2) & 7;
    endfunction

    assign reg_hit    = mapped(reg_addr);
    assign reg_rdata  = reg_hit ? regs[ridx(reg_addr)] : '0;
    assign fifo_data  = fmem[fhead % 16];
    assign fifo_empty = (fhead == ftail);

    always @(posedge clk) begin
        if (reg_wr)   regs[ridx(reg_addr)] <= reg_wdata;
        if (fifo_pop) fhead <= fhead + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] w);
        fmem[ftail % 16] = w;
        ftail = ftail + 1;
    endtask

    task automatic run_tx(input bit w, input logic [15:0] addr, input int n,
                          input logic [DW-1:0] seed);
        logic [15:0] a;
        int          head0;
        a = addr;
        head0 = fhead;
        @(negedge clk);
        ads_n = 0; wr_nrd = w; ad_i = {16'h0, addr};
        #1 chk(ad_oe == 0, "R10 addr cycle oe", 32'(ad_oe), 0);
        @(negedge clk);
        ads_n = 1;
        for (int i = 0; i < n; i++) begin
            ad_i   = w ? seed + DW'(i) : '0;
            last_n = (i == n - 1) ? 1'b0 : 1'b1;
            #1;
            chk(rdy_n == 0, "R2 beat ready", 32'(rdy_n), 0);
            if (w) begin
                chk(ad_oe == 0, "R10 write oe", 32'(ad_oe), 0);
                chk(reg_wr == (mapped(a) && addr != 0), "R3 write strobe", 32'(reg_wr),
                    32'(mapped(a)));
                if (mapped(a) && addr != 0) begin
                    chk(reg_addr == a && reg_wdata == seed + DW'(i), "R3 write addr/data",
                        reg_wdata, seed + DW'(i));
                    exp_regs[ridx(a)] = seed + DW'(i);
                end
            end else begin
                chk(ad_oe == 1, "R10 read oe", 32'(ad_oe), 1);
                if (i > 0)
                    chk(ad_o == (mapped(a) ? exp_regs[ridx(a)] : '0), "R6 burst read step",
                        ad_o, mapped(a) ? exp_regs[ridx(a)] : '0);
                else if (mapped(a))
                    chk(ad_o == exp_regs[ridx(a)], "R4 register read", ad_o, exp_regs[ridx(a)]);
                else
                    chk(ad_o == '0, "R5 unmapped read zero", ad_o, '0);
            end
            @(negedge clk);
            if (addr != 16'h0) a = a + 16'd4;
        end
        last_n = 1; ad_i = '0;
        #1;
        chk(ad_oe == 0, "R10 oe after last", 32'(ad_oe), 0);
        chk(rdy_n == 1, "R9 ended on last", 32'(rdy_n), 1);
        chk(fhead == head0, "R3 queue untouched", 32'(fhead), 32'(head0));
    endtask

    // {write, addr, beats, seed}
    localparam logic [52:0] VEC [8] = '{
        {1'b1, 16'h0010, 4'd1, 32'hA000_0000},
        {1'b0, 16'h0010, 4'd1, 32'h0},
        {1'b1, 16'h0018, 4'd3, 32'hB000_0010},
        {1'b0, 16'h0014, 4'd4, 32'h0},
        {1'b1, 16'h0040, 4'd1, 32'h0000_DEAD},
        {1'b0, 16'h0040, 4'd2, 32'h0},
        {1'b1, 16'h0000, 4'd1, 32'h0000_1234},
        {1'b0, 16'h0028, 4'd3, 32'h0}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bus_rst_n = 0; ads_n = 1; wr_nrd = 0; last_n = 1; ad_i = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(rdy_n == 1, "R1 reset rdy_n", 32'(rdy_n), 1);
        chk(ad_oe == 0, "R1 reset oe", 32'(ad_oe), 0);
        chk(reg_wr == 0 && reg_rd == 0, "R1 reset strobes", 32'(reg_wr), 0);
        chk(fifo_pop == 0, "R1 reset pop", 32'(fifo_pop), 0);
        @(negedge clk);
        bus_rst_n = 1;

        for (int v = 0; v < 8; v++)
            run_tx(VEC[v][52], VEC[v][51:36], int'(VEC[v][35:32]), VEC[v][31:0]);

        // queue streaming with a dry spell (R7, R8, R9)
        push(32'h1111_0001);
        push(32'h1111_0002);
        @(negedge clk);
        ads_n = 0; wr_nrd = 0; ad_i = '0;
        @(negedge clk);
        ads_n = 1; last_n = 1;
        #1 chk(rdy_n == 0 && fifo_pop == 1 && ad_o == 32'h1111_0001, "R7 queue word 1",
               ad_o, 32'h1111_0001);
        @(negedge clk);
        #1 chk(ad_o == 32'h1111_0002 && fifo_pop == 1, "R7 queue word 2", ad_o, 32'h1111_0002);
        @(negedge clk);
        last_n = 0;
        #1 chk(rdy_n == 1, "R8 empty stalls", 32'(rdy_n), 1);
        chk(fifo_pop == 0, "R8 no pop when empty", 32'(fifo_pop), 0);
        @(negedge clk);
        last_n = 1;
        #1 chk(ad_oe == 1 && rdy_n == 1, "R9 last during stall ignored", 32'(ad_oe), 1);
        @(negedge clk);
        push(32'h1111_0003);
        push(32'h1111_0004);
        #1 chk(rdy_n == 0 && ad_o == 32'h1111_0003, "R8 resumes with data", ad_o, 32'h1111_0003);
        @(negedge clk);
        last_n = 0;
        #1 chk(ad_o == 32'h1111_0004 && reg_addr == 16'h0, "R7 queue word 4 at addr 0",
               ad_o, 32'h1111_0004);
        @(negedge clk);
        last_n = 1;
        #1 chk(ad_oe == 0 && rdy_n == 1, "R9 burst closed", 32'(ad_oe), 0);
        chk(fhead == ftail, "R7 all words consumed", 32'(fhead), 32'(ftail));

        // reset during a read data phase (R1)
        @(negedge clk);
        ads_n = 0; wr_nrd = 0; ad_i = 32'h0000_0010;
        @(negedge clk);
        ads_n = 1; last_n = 1; ad_i = '0;
        #1 chk(ad_oe == 1, "R10 read in progress", 32'(ad_oe), 1);
        @(negedge clk);
        bus_rst_n = 0;
        @(negedge clk);
        #1 chk(ad_oe == 0 && rdy_n == 1, "R1 reset releases bus", 32'(ad_oe), 0);
        bus_rst_n = 1;
        @(negedge clk);
        #1 chk(ad_oe == 0 && rdy_n == 1, "R1 idle after reset", 32'(rdy_n), 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule